// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block is the digital divider chain of an integer-N frequency synthesizer. A prescaler divides the RF clock by either P or P+1. A swallow counter and a main counter steer it so that the RF clock is divided by N = B·P + A in total. P is chosen from four values. A separate reference counter divides the reference clock by R. Each divider produces a pulse one clock wide at the end of every output period. The two pulse trains would feed a phase/frequency comparator.

At the start of each RF output period the prescaler runs at P+1 for the first A prescaler cycles. It then runs at P for the remaining B−A prescaler cycles, so that B prescaler cycles make up one period. A, B, R and the prescaler select are sampled into internal copies only when a period ends. A new setting therefore never produces one period of mixed length. The same copies are also reloaded while the held setting is invalid, and on a counter clear. A synchronous clear restarts both dividers so that their periods begin together. With the default registered outputs, the first pulse arrives N RF cycles and R reference cycles after the clear is released.

Top module: `swallow_divider`

## Requirements
- R1: With a valid setting, `rf_pulse` recurs every N = B·P + A rising edges of `rf_clk`. This holds for A = 0, for A = B and for the largest prescaler.
- R2: `psc_sel` selects P as follows: 2'b00 gives P = 8, 2'b01 gives P = 16, 2'b10 gives P = 32 and 2'b11 gives P = 64.
- R3: With R of at least 2, `ref_pulse` recurs every R rising edges of `ref_clk`, for R values up to 16383.
- R4: Each pulse on `rf_pulse` and on `ref_pulse` is high for exactly one cycle of its own clock.
- R5: A setting with B < 3 or B < A produces no `rf_pulse`. Once a valid setting is applied, the pulse appears N+1 `rf_clk` edges later, where the first of those edges loads the setting.
- R6: An R of 0 or 1 produces no `ref_pulse`.
- R7: A change to A, B, P or R while a period is running does not alter that period. The new value governs the period that follows.
- R8: While `cnt_clr` is high both outputs stay low. After `cnt_clr` falls, the first `rf_pulse` comes at the N-th `rf_clk` rising edge and the first `ref_pulse` at the R-th `ref_clk` rising edge.
- R9: While `rst_n` is low, and until a full period has elapsed after reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rf_clk | input | 1 | RF clock (the prescaler input) |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cnt_clr | input | 1 | Synchronous counter clear, sampled in both clock domains |
| psc_sel | input | 2 | Prescaler pair select (see R2) |
| a_val | input | A_W (6) | Swallow count A |
| b_val | input | B_W (13) | Main count B |
| r_val | input | R_W (14) | Reference division ratio R |
| rf_pulse | output | 1 | One-cycle pulse per N RF cycles |
| ref_pulse | output | 1 | One-cycle pulse per R reference cycles |

## Verification
The hardest case to reach from the ports is a setting that changes in the middle of a running period. The change must be shown to affect only the following period, which is not visible in a single period measurement. The bench clears the dividers and counts a fixed number of clock edges into the period. It then rewrites B (or R) at a clock edge it does not share with the design. It checks that the current gap still ends at the old boundary and that the gap after it has the new length. Recovery from an invalid setting is reached in the same way: the valid value is written while the divider is idle, and the delay to the first pulse is counted from that write.

// File: rtl/swd_pkg.sv
package swd_pkg;
   // Width of the prescaler phase counter; the largest modulus (65) fits.
   localparam int PSC_W = 7;

   typedef enum logic [1:0] {
      PSC_DIV8  = 2'b00,
      PSC_DIV16 = 2'b01,
      PSC_DIV32 = 2'b10,
      PSC_DIV64 = 2'b11
   } psc_sel_e;

   // Base modulus P for a select code: 8 shifted left by the code.
   function automatic logic [PSC_W-1:0] psc_base(input logic [1:0] sel);
      return PSC_W'(8) << sel;
   endfunction
endpackage

// File: rtl/swd_prescaler.sv
module swd_prescaler
   import swd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       run,
   input  logic       swallow,
   input  logic [1:0] sel,
   output logic       tick
);
   logic [PSC_W-1:0] pcnt;
   logic [PSC_W-1:0] top_val;

   // The terminal count is P-1, or P when this cycle swallows one extra input edge.
   assign top_val = psc_base(sel) + {{(PSC_W-1){1'b0}}, swallow} - PSC_W'(1);
   assign tick    = run && (pcnt == top_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pcnt <= '0;
      else if (clr || !run || tick) pcnt <= '0;
      else                          pcnt <= pcnt + PSC_W'(1);
   end

   // R2: the phase never passes the terminal count of the selected modulus.
   p_phase_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= top_val);
endmodule

// File: rtl/swd_ab_ctrl.sv
module swd_ab_ctrl #(
   parameter int A_W = 6,
   parameter int B_W = 13
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic [1:0]     sel_in,
   input  logic [A_W-1:0] a_in,
   input  logic [B_W-1:0] b_in,
   input  logic           ps_tick,
   output logic           run,
   output logic           swallow,
   output logic [1:0]     sel_act,
   output logic           wrap
);
   localparam logic [B_W-1:0] B_MIN = B_W'(3);

   logic [A_W-1:0] act_a, a_cnt;
   logic [B_W-1:0] act_b, b_cnt;
   logic           act_ok, last, load;

   assign act_ok  = (act_b >= B_MIN) && (act_b >= B_W'(act_a));
   assign last    = (b_cnt == act_b - B_W'(1));
   assign wrap    = ps_tick && last;
   // The held setting is replaced at a period end, on a clear, or while it is invalid.
   assign load    = clr || !act_ok || wrap;
   assign run     = act_ok && !clr;
   assign swallow = (a_cnt < act_a);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_a   <= '0;
         act_b   <= '0;
         sel_act <= 2'b00;
         a_cnt   <= '0;
         b_cnt   <= '0;
      end else if (load) begin
         act_a   <= a_in;
         act_b   <= b_in;
         sel_act <= sel_in;
         a_cnt   <= '0;
         b_cnt   <= '0;
      end else if (ps_tick) begin
         b_cnt <= b_cnt + B_W'(1);
         if (swallow) a_cnt <= a_cnt + A_W'(1);
      end
   end

   // R1: the swallow count never runs ahead of the main count.
   p_swallow_behind_main_r1: assert property (@(posedge clk) disable iff (!rst_n)
      B_W'(a_cnt) <= b_cnt);
   // R7: without a load the held setting does not move.
   p_setting_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(act_a) && $stable(act_b) && $stable(sel_act)));
   // R5: an invalid setting never closes a period.
   p_invalid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !act_ok |=> !wrap);
endmodule

// File: rtl/swd_ref_div.sv
module swd_ref_div #(
   parameter int R_W = 14
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic [R_W-1:0] r_in,
   output logic           wrap
);
   localparam logic [R_W-1:0] R_MIN = R_W'(2);

   logic [R_W-1:0] act_r, rcnt;
   logic           act_ok, last;

   assign act_ok = (act_r >= R_MIN);
   assign last   = (rcnt == act_r - R_W'(1));
   assign wrap   = act_ok && !clr && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_r <= '0;
         rcnt  <= '0;
      end else if (clr || !act_ok || last) begin
         act_r <= r_in;
         rcnt  <= '0;
      end else begin
         rcnt  <= rcnt + R_W'(1);
      end
   end

   // R3: with a valid ratio the count stays below R.
   p_ref_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      act_ok |-> (rcnt < act_r));
   // R6: a ratio below 2 never produces a period end.
   p_ref_invalid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !act_ok |=> !wrap);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
   parameter int A_W     = 6,
   parameter int B_W     = 13,
   parameter int R_W     = 14,
   parameter int OUT_REG = 1
) (
   input  logic           rf_clk,
   input  logic           ref_clk,
   input  logic           rst_n,
   input  logic           cnt_clr,
   input  logic [1:0]     psc_sel,
   input  logic [A_W-1:0] a_val,
   input  logic [B_W-1:0] b_val,
   input  logic [R_W-1:0] r_val,
   output logic           rf_pulse,
   output logic           ref_pulse
);
   if (A_W < 1 || A_W >= B_W) begin : g_bad_ab
      $error("swallow_divider: A_W must be at least 1 and below B_W");
   end
   if (R_W < 2) begin : g_bad_r
      $error("swallow_divider: R_W must be at least 2");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
      $error("swallow_divider: OUT_REG must be 0 or 1");
   end

   logic       ps_tick, ps_run, ps_swallow, rf_wrap, ref_wrap;
   logic [1:0] ps_sel;

   swd_prescaler u_psc (
      .clk     (rf_clk),
      .rst_n   (rst_n),
      .clr     (cnt_clr),
      .run     (ps_run),
      .swallow (ps_swallow),
      .sel     (ps_sel),
      .tick    (ps_tick)
   );

   swd_ab_ctrl #(.A_W(A_W), .B_W(B_W)) u_ab (
      .clk     (rf_clk),
      .rst_n   (rst_n),
      .clr     (cnt_clr),
      .sel_in  (psc_sel),
      .a_in    (a_val),
      .b_in    (b_val),
      .ps_tick (ps_tick),
      .run     (ps_run),
      .swallow (ps_swallow),
      .sel_act (ps_sel),
      .wrap    (rf_wrap)
   );

   swd_ref_div #(.R_W(R_W)) u_ref (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .r_in  (r_val),
      .wrap  (ref_wrap)
   );

   if (OUT_REG != 0) begin : g_out_reg
      always_ff @(posedge rf_clk or negedge rst_n) begin
         if (!rst_n) rf_pulse <= 1'b0;
         else        rf_pulse <= rf_wrap;
      end
      always_ff @(posedge ref_clk or negedge rst_n) begin
         if (!rst_n) ref_pulse <= 1'b0;
         else        ref_pulse <= ref_wrap;
      end
   end else begin : g_out_comb
      assign rf_pulse  = rf_wrap;
      assign ref_pulse = ref_wrap;
   end

   // R4: pulses are exactly one cycle of their own clock wide.
   p_rf_one_wide_r4: assert property (@(posedge rf_clk) disable iff (!rst_n)
      rf_pulse |=> !rf_pulse);
   p_ref_one_wide_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ref_pulse |=> !ref_pulse);
   // R8: a clear keeps both outputs quiet.
   p_rf_clr_quiet_r8: assert property (@(posedge rf_clk) disable iff (!rst_n)
      cnt_clr |=> !rf_pulse);
   p_ref_clr_quiet_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      cnt_clr |=> !ref_pulse);
endmodule

// File: tb/swallow_divider_bench.sv
module swallow_divider_bench;
   localparam int RF_PERIOD  = 10;
   localparam int REF_PERIOD = 14;
   localparam int GAP_LIMIT  = 20000;

   logic        rf_clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0, cnt_clr = 1'b0;
   logic [1:0]  psc_sel = 2'b00;
   logic [5:0]  a_val = '0;
   logic [12:0] b_val = 13'd3;
   logic [13:0] r_val = 14'd100;
   logic        rf_pulse, ref_pulse;

   int n_vec = 0, n_bad = 0;
   bit done = 1'b0;

   swallow_divider u_swallow_divider (
      .rf_clk(rf_clk), .ref_clk(ref_clk), .rst_n(rst_n), .cnt_clr(cnt_clr),
      .psc_sel(psc_sel), .a_val(a_val), .b_val(b_val), .r_val(r_val),
      .rf_pulse(rf_pulse), .ref_pulse(ref_pulse)
   );

   initial forever #(RF_PERIOD/2)  rf_clk  = ~rf_clk;
   initial forever #(REF_PERIOD/2) ref_clk = ~ref_clk;

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic rf_gap(output int n);
      n = 0;
      do begin @(posedge rf_clk); #1; n++; end while (!rf_pulse && n < GAP_LIMIT);
   endtask

   task automatic ref_gap(output int n);
      n = 0;
      do begin @(posedge ref_clk); #1; n++; end while (!ref_pulse && n < GAP_LIMIT);
   endtask

   task automatic rf_hits(input int cycles, output int hits);
      hits = 0;
      for (int i = 0; i < cycles; i++) begin
         @(posedge rf_clk); #1;
         if (rf_pulse) hits++;
      end
   endtask

   task automatic ref_hits(input int cycles, output int hits);
      hits = 0;
      for (int i = 0; i < cycles; i++) begin
         @(posedge ref_clk); #1;
         if (ref_pulse) hits++;
      end
   endtask

   task automatic set_rf(input logic [1:0] s, input int a, input int b);
      @(negedge rf_clk);
      psc_sel = s; a_val = 6'(a); b_val = 13'(b);
   endtask

   // Clear is driven on RF falling edges; reference rising edges never coincide with them.
   task automatic do_clr();
      @(negedge rf_clk) cnt_clr = 1'b1;
      repeat (2) @(posedge ref_clk);
      @(negedge rf_clk) cnt_clr = 1'b0;
   endtask

   task automatic t_reset();
      int h1, h2;
      chk("R9 rf_pulse in reset", int'(rf_pulse), 0);
      chk("R9 ref_pulse in reset", int'(ref_pulse), 0);
      @(negedge rf_clk) rst_n = 1'b1;
      fork
         rf_hits(20, h1);
         ref_hits(14, h2);
      join
      chk("R9 rf quiet after reset", h1, 0);
      chk("R9 ref quiet after reset", h2, 0);
   endtask

   task automatic t_ratio(input logic [1:0] s, input int a, input int b, input int p);
      int n, g;
      n = b * p + a;
      set_rf(s, a, b);
      do_clr();
      rf_gap(g);  chk("R8 first rf pulse after clear", g, n);
      @(posedge rf_clk); #1;
      chk("R4 rf pulse one cycle wide", int'(rf_pulse), 0);
      rf_gap(g);  chk("R1/R2 rf period (after width sample)", g, n - 1);
      rf_gap(g);  chk("R1/R2 rf period", g, n);
   endtask

   task automatic t_ref(input int r);
      int g;
      @(negedge rf_clk) r_val = 14'(r);
      do_clr();
      ref_gap(g); chk("R8 first ref pulse after clear", g, r);
      @(posedge ref_clk); #1;
      chk("R4 ref pulse one cycle wide", int'(ref_pulse), 0);
      ref_gap(g); chk("R3 ref period (after width sample)", g, r - 1);
      ref_gap(g); chk("R3 ref period", g, r);
   endtask

   task automatic t_align();
      int g1, g2;
      set_rf(2'b00, 3, 3);
      @(negedge rf_clk) r_val = 14'd9;
      do_clr();
      fork
         rf_gap(g1);
         ref_gap(g2);
      join
      chk("R8 aligned restart rf", g1, 27);
      chk("R8 aligned restart ref", g2, 9);
   endtask

   task automatic t_switch();
      int g;
      set_rf(2'b00, 1, 3);              // N = 25
      do_clr();
      repeat (10) @(posedge rf_clk);
      @(negedge rf_clk) b_val = 13'd5;  // N becomes 41 from the next period
      rf_gap(g); chk("R7 running rf period kept", g, 15);
      rf_gap(g); chk("R7 new rf period", g, 41);
      @(negedge rf_clk) r_val = 14'd6;
      do_clr();
      repeat (2) @(posedge ref_clk);
      @(negedge rf_clk) r_val = 14'd9;
      ref_gap(g); chk("R7 running ref period kept", g, 4);
      ref_gap(g); chk("R7 new ref period", g, 9);
   endtask

   task automatic t_rf_invalid();
      int h, g;
      set_rf(2'b00, 0, 2);
      do_clr();
      rf_hits(300, h); chk("R5 B below 3 idle", h, 0);
      set_rf(2'b00, 5, 4);
      rf_hits(300, h); chk("R5 B below A idle", h, 0);
      set_rf(2'b00, 0, 3);
      rf_gap(g); chk("R5 recovery to valid setting", g, 25);
   endtask

   task automatic t_ref_invalid();
      int h, g;
      @(negedge rf_clk) r_val = 14'd1;
      do_clr();
      ref_hits(100, h); chk("R6 R of 1 idle", h, 0);
      @(negedge rf_clk) r_val = 14'd0;
      ref_hits(100, h); chk("R6 R of 0 idle", h, 0);
      @(negedge rf_clk) r_val = 14'd4;
      ref_gap(g); chk("R6 recovery to R of 4", g, 5);
   endtask

   initial begin
      #(RF_PERIOD * 3);
      t_reset();
      t_ratio(2'b00, 0, 3, 8);     // N = 24, no swallow
      t_ratio(2'b00, 3, 3, 8);     // A = B
      t_ratio(2'b00, 2, 5, 8);
      t_ratio(2'b01, 2, 5, 16);
      t_ratio(2'b10, 2, 5, 32);
      t_ratio(2'b11, 2, 5, 64);
      t_ratio(2'b11, 63, 63, 64);  // N = 4095
      t_ref(2);
      t_ref(5);
      t_align();
      t_switch();
      t_rf_invalid();
      t_ref_invalid();
      t_ref(16383);
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      end
      $finish;
   end

   initial begin
      #(RF_PERIOD * 190000);
      if (!done) begin
         done = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got 1 expected 0 (run did not complete)");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      end
      $finish;
   end
endmodule